// File: doc/BRIEF.md
# Three-Digit Combination Lock Controller

This block opens a lock once three 4-bit digits arrive in the programmed order. Digits come in over a small valid/ready stream. `dig_valid` qualifies `dig_value`, and a digit counts as entered only in a cycle where both `dig_valid` and `dig_ready` are high.

The block stores the combination in three code registers. Each register is written from the same value bus by its own load strobe. An AND-OR selector picks the code register for the digit the controller expects next, and an equality compare decides whether the controller steps forward or drops into a locked-out error state.

The controller state is one-hot over the digit positions, with an extra top bit for the open condition, and error is all zeros. Because of this encoding, the selector control and the open indication are plain slices of the state register and need no decode logic. Software, or a keypad front end that has already debounced its keys, drives the stream. Any timeout belongs to the surroundings.

Top module: `combo_lock`

## Requirements
- R1: A synchronous active-high `rst` returns the controller to the first-digit state. In that state `sel` = 3'b001 and `is_open` = 0. `rst` also reloads the code registers with the combination 3, 4, 2, with code register 0 holding 3 and code register 2 holding 2.
- R2: In any state, a cycle with no accepted digit (`dig_valid` low, or `dig_ready` low) leaves `sel` and `is_open` unchanged.
- R3: When an accepted digit equals the code register named by the one-hot `sel`, the next state is the following position. `sel` steps 001 to 010 to 100, and after a match at 100 the outputs become `is_open` = 1 with `sel` = 000.
- R4: When an accepted digit differs from the selected code register in any of the three digit states, the controller goes to the error state (`sel` = 000, `is_open` = 0). This applies to the first, middle and last digit alike.
- R5: The open state and the error state are left only through `rst`. Accepted digits, whether right or wrong, have no effect there.
- R6: `is_open` is 1 only in the open state. `{is_open, sel}` is never more than one-hot.
- R7: `load_en[i]` high writes `dig_value` into code register i at the clock edge. Bit 0 is the first digit and bit 2 the last. After loading, only the new combination opens the lock.
- R8: `dig_ready` is low in every cycle in which any bit of `load_en` is high. The digit offered in that cycle is not consumed and does not move the state. Otherwise `dig_ready` is high, so the source only has to hold off while loading.
- R9: `rst` together with a load strobe in the same cycle leaves the reset combination 3, 4, 2 in the code registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dig_valid | input | 1 | Stream valid for the entered digit |
| dig_ready | output | 1 | Stream ready; low while any load strobe is high |
| dig_value | input | 4 | Digit value, also the code register load data |
| load_en | input | 3 | Per-register load strobes, bit i writes code register i |
| sel | output | 3 | One-hot code select, low state bits |
| is_open | output | 1 | Lock open, top state bit |

## Verification
The bench builds the block with its default parameters: three digits of four bits and the reset combination 3, 4, 2. With these values every state and every selector input can be reached in a few dozen cycles. Each mismatch position, reprogramming of all three registers, and the clash between a load and a digit in the same cycle are all exercised with short scripted sequences.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int unsigned DEF_DIGIT_W    = 4;
  localparam int unsigned DEF_NUM_DIGITS = 3;

  // Returns the state after an accepted digit: step the one-hot token up or clear it.
  function automatic logic [DEF_NUM_DIGITS:0] step_state(
    input logic [DEF_NUM_DIGITS:0] cur,
    input logic                    hit
  );
    step_state = hit ? (cur << 1) : '0;
  endfunction
endpackage

// File: rtl/code_bank.sv
module code_bank #(
  parameter int unsigned DIGIT_W    = 4,
  parameter int unsigned NUM_DIGITS = 3,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] RESET_CODE = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_DIGITS-1:0]         load_en,
  input  logic [DIGIT_W-1:0]            wr_value,
  output logic [NUM_DIGITS*DIGIT_W-1:0] codes_flat
);
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_reg
    logic [DIGIT_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst)
        code_q <= RESET_CODE[g*DIGIT_W +: DIGIT_W];
      else if (load_en[g])
        code_q <= wr_value;
    end
    assign codes_flat[g*DIGIT_W +: DIGIT_W] = code_q;
  end
endmodule

// File: rtl/digit_select.sv
module digit_select #(
  parameter int unsigned DIGIT_W    = 4,
  parameter int unsigned NUM_DIGITS = 3
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] codes_flat,
  input  logic [NUM_DIGITS-1:0]         sel,
  input  logic [DIGIT_W-1:0]            probe,
  output logic                          equal
);
  logic [DIGIT_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_DIGITS; i++)
      picked |= {DIGIT_W{sel[i]}} & codes_flat[i*DIGIT_W +: DIGIT_W];
  end

  assign equal = (picked == probe);
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import combo_lock_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = DEF_NUM_DIGITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  accept,
  input  logic                  equal,
  output logic [NUM_DIGITS-1:0] sel,
  output logic                  is_open
);
  localparam int unsigned ST_W = NUM_DIGITS + 1;
  localparam logic [ST_W-1:0] ST_FIRST = ST_W'(1);

  logic [ST_W-1:0] st_q;
  logic            entering;

  assign entering = |st_q[NUM_DIGITS-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      st_q <= ST_FIRST;
    else if (accept && entering)
      st_q <= step_state(st_q, equal);
  end

  assign sel     = st_q[NUM_DIGITS-1:0];
  assign is_open = st_q[NUM_DIGITS];
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
#(
  parameter int unsigned DIGIT_W    = DEF_DIGIT_W,
  parameter int unsigned NUM_DIGITS = DEF_NUM_DIGITS,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] RESET_CODE = {4'd2, 4'd4, 4'd3}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dig_valid,
  output logic                  dig_ready,
  input  logic [DIGIT_W-1:0]    dig_value,
  input  logic [NUM_DIGITS-1:0] load_en,
  output logic [NUM_DIGITS-1:0] sel,
  output logic                  is_open
);
  localparam int unsigned FLAT_W = NUM_DIGITS * DIGIT_W;

  logic [FLAT_W-1:0] codes_flat;
  logic              equal;
  logic              accept;

  assign dig_ready = ~|load_en;
  assign accept    = dig_valid & dig_ready;

  code_bank #(
    .DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS), .RESET_CODE(RESET_CODE)
  ) u_bank (
    .clk(clk), .rst(rst), .load_en(load_en), .wr_value(dig_value),
    .codes_flat(codes_flat)
  );

  digit_select #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_sel (
    .codes_flat(codes_flat), .sel(sel), .probe(dig_value), .equal(equal)
  );

  lock_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .equal(equal),
    .sel(sel), .is_open(is_open)
  );
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
  parameter int unsigned NUM_DIGITS = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  dig_valid,
  input logic                  dig_ready,
  input logic [NUM_DIGITS-1:0] load_en,
  input logic [NUM_DIGITS-1:0] sel,
  input logic                  is_open
);
  logic taken;
  assign taken = dig_valid && dig_ready;

  AST_RESET_FIRST: assert property (@(posedge clk) rst |=> (sel == NUM_DIGITS'(1) && !is_open)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !taken |=> $stable({is_open, sel})); // R2
  AST_STEP_OR_FAIL: assert property (@(posedge clk) disable iff (rst) (taken && sel != '0) |=> ({is_open, sel} == {$past(sel), 1'b0} || {is_open, sel} == '0)); // R3
  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst) is_open |=> is_open); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) (!is_open && sel == '0) |=> (!is_open && sel == '0)); // R5
  AST_STATE_ONEHOT0: assert property (@(posedge clk) disable iff (rst) $onehot0({is_open, sel})); // R6
  AST_LOAD_STALLS: assert property (@(posedge clk) disable iff (rst) (|load_en) |-> !dig_ready); // R8
endmodule

bind combo_lock combo_lock_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk(clk), .rst(rst), .dig_valid(dig_valid), .dig_ready(dig_ready),
  .load_en(load_en), .sel(sel), .is_open(is_open)
);

// File: tb/combo_lock_tb_top.sv
`timescale 1ns/1ps
module combo_lock_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       dig_valid;
  logic       dig_ready;
  logic [3:0] dig_value;
  logic [2:0] load_en;
  logic [2:0] sel;
  logic       is_open;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  combo_lock dut_i (
    .clk(clk), .rst(rst), .dig_valid(dig_valid), .dig_ready(dig_ready),
    .dig_value(dig_value), .load_en(load_en), .sel(sel), .is_open(is_open)
  );

  // vector: {rst, valid, load_en[2:0], value[3:0], exp_ready, exp_state{open,sel}}
  localparam int NV = 26;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'b000, 4'h0, 1'b1, 4'b0001}, // R1 reset
    {1'b0, 1'b0, 3'b000, 4'h3, 1'b1, 4'b0001}, // R2 idle
    {1'b0, 1'b1, 3'b000, 4'h3, 1'b1, 4'b0010}, // R3
    {1'b0, 1'b0, 3'b000, 4'h9, 1'b1, 4'b0010}, // R2
    {1'b0, 1'b1, 3'b000, 4'h4, 1'b1, 4'b0100}, // R3
    {1'b0, 1'b1, 3'b000, 4'h2, 1'b1, 4'b1000}, // R3 open
    {1'b0, 1'b1, 3'b000, 4'h3, 1'b1, 4'b1000}, // R5 open sticky
    {1'b1, 1'b0, 3'b000, 4'h0, 1'b1, 4'b0001}, // R1
    {1'b0, 1'b1, 3'b000, 4'h3, 1'b1, 4'b0010},
    {1'b0, 1'b1, 3'b000, 4'h5, 1'b1, 4'b0000}, // R4 middle
    {1'b0, 1'b1, 3'b000, 4'h4, 1'b1, 4'b0000}, // R5 err sticky
    {1'b1, 1'b0, 3'b000, 4'h0, 1'b1, 4'b0001},
    {1'b0, 1'b1, 3'b000, 4'h7, 1'b1, 4'b0000}, // R4 first
    {1'b1, 1'b0, 3'b000, 4'h0, 1'b1, 4'b0001},
    {1'b0, 1'b1, 3'b001, 4'h9, 1'b0, 4'b0001}, // R7 R8
    {1'b0, 1'b1, 3'b010, 4'h1, 1'b0, 4'b0001}, // R7 R8
    {1'b0, 1'b1, 3'b100, 4'hF, 1'b0, 4'b0001}, // R7 R8
    {1'b0, 1'b1, 3'b000, 4'h9, 1'b1, 4'b0010}, // R7
    {1'b0, 1'b1, 3'b000, 4'h1, 1'b1, 4'b0100}, // R7
    {1'b0, 1'b1, 3'b000, 4'hF, 1'b1, 4'b1000}, // R7 open
    {1'b1, 1'b0, 3'b000, 4'h0, 1'b1, 4'b0001}, // R1 codes back
    {1'b0, 1'b1, 3'b000, 4'h3, 1'b1, 4'b0010}, // R1
    {1'b0, 1'b1, 3'b000, 4'h4, 1'b1, 4'b0100},
    {1'b0, 1'b1, 3'b000, 4'h3, 1'b1, 4'b0000}, // R4 last
    {1'b1, 1'b0, 3'b000, 4'h0, 1'b1, 4'b0001},
    {1'b0, 1'b1, 3'b000, 4'h3, 1'b1, 4'b0010}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic v, input logic [2:0] ld, input logic [3:0] val);
    rst = r; dig_valid = v; load_en = ld; dig_value = val;
  endtask

  initial begin
    drive(1'b1, 1'b0, 3'b000, 4'h0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8:5]);
      #1;
      check("R8 ready", dig_ready, VEC[i][4]);
      @(posedge clk);
      @(negedge clk);
      check("R3/R4/R5 state", {is_open, sel}, VEC[i][3:0]);
      drive(1'b0, 1'b0, 3'b000, 4'h0);
    end
    // R9: reset with a load strobe keeps the reset combination
    @(negedge clk); drive(1'b1, 1'b0, 3'b111, 4'hA);
    @(negedge clk); drive(1'b0, 1'b1, 3'b000, 4'h3);
    check("R9 first state", {is_open, sel}, 4'b0001);
    @(negedge clk); drive(1'b0, 1'b1, 3'b000, 4'h4);
    @(negedge clk); drive(1'b0, 1'b1, 3'b000, 4'h2);
    @(negedge clk); drive(1'b0, 1'b0, 3'b000, 4'h0);
    check("R9 open after 3,4,2", {is_open, sel}, 4'b1000);
    check("R6 open", is_open, 1'b1);
    // R2: a long idle run with changing values does not move the state
    @(negedge clk); drive(1'b1, 1'b0, 3'b000, 4'h0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); drive(1'b0, 1'b0, 3'b000, 4'(k + 3));
    end
    @(negedge clk);
    check("R2 long idle", {is_open, sel}, 4'b0001);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule